// File: doc/BRIEF.md
# UART Transmit Core with Hardware Flow Control

This block is the transmit side of a serial port, together with the hardware handshake logic on both directions of the link. Characters are written into a 16-entry transmit queue. A serializer sends them on the TX line as 8N1 frames: one low start bit, eight data bits with the LSB first, and one high stop bit. Every bit lasts 16 pulses of an external baud tick. When clear-to-send gating is on, the serializer looks at a synchronized, active-low clear-to-send input only at the point where a new character would begin. A character that has started is always sent to the end.

On the receive side the block does not hold any data. It takes the fill level of the external receive queue as an input and compares it with a programmable watermark to drive an active-low request-to-send output. It also reports when that queue is completely full. A single control word holds the port enable, the watermark and the two handshake enables. While the port is enabled, only the enable bit of that word can change, so software must stop the port before it reprograms the rest. Stopping the port during a character lets the character finish.

Top module: `uart_flow_tx`

## Requirements
- R1: After reset the TX line is high, rts_n is low, tx_busy is low, tx_empty is high, and tx_full and tx_overflow are low.
- R2: Each character is sent as one low start bit, eight data bits with the LSB first, and one high stop bit, each bit lasting 16 baud ticks. The TX line is high whenever no character is in flight. With clear-to-send gating off (control bit 15 = 0), queued characters go out one after another until the queue is empty, whatever cts_n is.
- R3: The transmit queue holds 16 characters, and tx_full is high while it holds 16. A write made while it is full is dropped and sets tx_overflow, which then stays high until reset. tx_full and tx_empty are never high together.
- R4: With clear-to-send gating on (control bit 15 = 1), a character starts only if the port is enabled, the queue is not empty and cts_n, after a two-flop synchronizer, is low. While cts_n is high, no character starts.
- R5: If cts_n rises while a character is being shifted out, that character is sent in full. The next one waits until cts_n is low again.
- R6: The port enable is control bit 0. Clearing it during a character lets that character complete, then the transmitter stays idle, with characters held in the queue, until the port is enabled again.
- R7: A control write made while the port is enabled changes only the enable bit (bit 0). Bits 8 to 15 keep their previous values.
- R8: With request-to-send on (control bit 14 = 1) and the watermark in control bits 12..8, rts_n is high when rx_level is at or above the watermark and low when it is below. rts_n follows one clock after rx_level changes.
- R9: With request-to-send off (control bit 14 = 0), rts_n is held low.
- R10: rx_full is high exactly when rx_level equals the receive queue depth of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: bit 0 enable, bits 12..8 watermark, bit 14 request-to-send enable, bit 15 clear-to-send enable |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_wr | input | 1 | Transmit queue write strobe |
| tx_data | input | 8 | Character to queue |
| rx_level | input | 5 | Fill level of the external receive queue |
| cts_n | input | 1 | Active-low clear-to-send from the link partner (asynchronous) |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Active-low request-to-send |
| tx_busy | output | 1 | A character is being shifted out |
| tx_full | output | 1 | Transmit queue holds 16 characters |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_overflow | output | 1 | Sticky: a write was dropped because the queue was full |
| rx_full | output | 1 | Receive queue level equals its depth |

## Verification
A serializer that loses its place in a frame shows up on txd within one bit time, 16 baud ticks: a data bit is sampled wrongly, or the stop bit is missing where a frame monitor expects it. A gating decision taken at the wrong moment, such as a character starting while cts_n is high or the port is disabled, or a character cut short, shows up as an extra or missing frame, or as tx_busy stuck at a wrong value after one frame time. Corrupted control bits or watermark storage appear on rts_n one clock after the next change of rx_level.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  localparam int CTRL_W  = 16;
  localparam int EN_BIT  = 0;
  localparam int WM_LO   = 8;
  localparam int WM_W    = 5;
  localparam int RTS_BIT = 14;
  localparam int CTS_BIT = 15;

  typedef struct packed {
    logic            cts_en;
    logic            rts_en;
    logic [WM_W-1:0] wm;
    logic            en;
  } ctrl_t;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
  import uart_flow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl
);
  ctrl_t ctrl_q, ctrl_d;
  logic  unused_bits;

  assign unused_bits = ^{wdata[WM_LO-1:EN_BIT+1], wdata[RTS_BIT-1:WM_LO+WM_W]};

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      ctrl_d.en = wdata[EN_BIT];
      if (!ctrl_q.en) begin
        ctrl_d.wm     = wdata[WM_LO +: WM_W];
        ctrl_d.rts_en = wdata[RTS_BIT];
        ctrl_d.cts_en = wdata[CTS_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (we) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/uart_txfifo.sv
module uart_txfifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty,
  output logic          overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q | (wr && full);
    if (do_wr) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wdata;
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_flow_pkg::*;
#(
  parameter int DW            = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          frame_end
);
  localparam int FRAME_BITS = DW + 2;
  localparam int TICK_W     = $clog2(TICKS_PER_BIT);
  localparam int BIT_W      = $clog2(FRAME_BITS);

  tx_state_e             st_q, st_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [TICK_W-1:0]     tk_q, tk_d;
  logic [BIT_W-1:0]      bc_q, bc_d;
  logic                  tick_last, bit_last;

  assign tick_last = (tk_q == TICK_W'(TICKS_PER_BIT-1));
  assign bit_last  = (bc_q == BIT_W'(FRAME_BITS-1));
  assign frame_end = (st_q == TX_SEND) && baud_tick && tick_last && bit_last;

  always_comb begin
    st_d = st_q;
    sr_d = sr_q;
    tk_d = tk_q;
    bc_d = bc_q;
    case (st_q)
      TX_IDLE: begin
        if (start) begin
          st_d = TX_SEND;
          sr_d = {1'b1, data, 1'b0};
          tk_d = '0;
          bc_d = '0;
        end
      end
      TX_SEND: begin
        if (baud_tick) begin
          if (tick_last) begin
            tk_d = '0;
            if (bit_last) begin
              st_d = TX_IDLE;
            end else begin
              sr_d = {1'b1, sr_q[FRAME_BITS-1:1]};
              bc_d = bc_q + 1'b1;
            end
          end else begin
            tk_d = tk_q + 1'b1;
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE;
      sr_q <= '1;
      tk_q <= '0;
      bc_q <= '0;
    end else begin
      st_q <= st_d;
      sr_q <= sr_d;
      tk_q <= tk_d;
      bc_q <= bc_d;
    end
  end

  assign busy = (st_q == TX_SEND);
  assign txd  = busy ? sr_q[0] : 1'b1;
endmodule

// File: rtl/uart_rts_gen.sv
module uart_rts_gen #(
  parameter int LVL_W = 5,
  parameter int WM_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rts_en,
  input  logic [WM_W-1:0]  wm,
  input  logic [LVL_W-1:0] level,
  output logic             rts_n
);
  logic rts_n_q, rts_n_d;

  always_comb begin
    rts_n_d = rts_en && (int'(level) >= int'(wm));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n_q <= 1'b0;
    else        rts_n_q <= rts_n_d;
  end

  assign rts_n = rts_n_q;
endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx
  import uart_flow_pkg::*;
#(
  parameter int DW            = 8,
  parameter int TX_DEPTH      = 16,
  parameter int RX_DEPTH      = 16,
  parameter int TICKS_PER_BIT = 16,
  localparam int LVL_W        = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              baud_tick,
  input  logic              tx_wr,
  input  logic [DW-1:0]     tx_data,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              cts_n,
  output logic              txd,
  output logic              rts_n,
  output logic              tx_busy,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_overflow,
  output logic              rx_full
);
  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic [1:0]    cts_sync_q;
  logic          cts_s;
  ctrl_t         ctrl_q;
  logic [DW-1:0] fifo_rdata;
  logic          start;
  logic          frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) cts_sync_q <= 2'b11;
    else          cts_sync_q <= {cts_sync_q[0], cts_n};
  end
  assign cts_s = cts_sync_q[1];

  uart_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (ctrl_we),
    .wdata (ctrl_wdata),
    .ctrl  (ctrl_q)
  );

  assign start = !tx_busy && ctrl_q.en && !tx_empty && (!ctrl_q.cts_en || !cts_s);

  uart_txfifo #(.DW(DW), .DEPTH(TX_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr       (tx_wr),
    .wdata    (tx_data),
    .rd       (start),
    .rdata    (fifo_rdata),
    .full     (tx_full),
    .empty    (tx_empty),
    .overflow (tx_overflow)
  );

  uart_tx_shifter #(.DW(DW), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .baud_tick (baud_tick),
    .start     (start),
    .data      (fifo_rdata),
    .txd       (txd),
    .busy      (tx_busy),
    .frame_end (frame_end)
  );

  uart_rts_gen #(.LVL_W(LVL_W), .WM_W(WM_W)) u_rts (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .rts_en (ctrl_q.rts_en),
    .wm     (ctrl_q.wm),
    .level  (rx_level),
    .rts_n  (rts_n)
  );

  assign rx_full = (rx_level == LVL_W'(RX_DEPTH));
endmodule

// File: rtl/uart_flow_tx_chk.sv
module uart_flow_tx_chk #(
  parameter int LVL_W = 5,
  parameter int WM_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             rts_n,
  input logic             tx_busy,
  input logic             tx_full,
  input logic             tx_empty,
  input logic             tx_overflow,
  input logic             en,
  input logic             rts_en,
  input logic             cts_en,
  input logic [WM_W-1:0]  wm,
  input logic [LVL_W-1:0] rx_level,
  input logic             cts_s,
  input logic             frame_end
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty)); // R3
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |=> tx_overflow); // R3
  AST_CTS_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && cts_en && cts_s) |=> !tx_busy); // R4
  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !frame_end) |=> tx_busy); // R5
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !en) |=> !tx_busy); // R6
  AST_RTS_AT_WATERMARK: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && int'(rx_level) >= int'(wm)) |=> rts_n); // R8
  AST_RTS_BELOW_WATERMARK: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && int'(rx_level) < int'(wm)) |=> !rts_n); // R8
  AST_RTS_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_en |=> !rts_n); // R9
endmodule

bind uart_flow_tx uart_flow_tx_chk #(.LVL_W(LVL_W), .WM_W(uart_flow_pkg::WM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_i_n),
  .txd         (txd),
  .rts_n       (rts_n),
  .tx_busy     (tx_busy),
  .tx_full     (tx_full),
  .tx_empty    (tx_empty),
  .tx_overflow (tx_overflow),
  .en          (ctrl_q.en),
  .rts_en      (ctrl_q.rts_en),
  .cts_en      (ctrl_q.cts_en),
  .wm          (ctrl_q.wm),
  .rx_level    (rx_level),
  .cts_s       (cts_s),
  .frame_end   (frame_end)
);

// File: tb/uart_flow_tx_bench.sv
module uart_flow_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 32;

  logic        clk;
  logic        rst_n;
  logic        ctrl_we;
  logic [15:0] ctrl_wdata;
  logic        baud_tick;
  logic        tx_wr;
  logic [7:0]  tx_data;
  logic [4:0]  rx_level;
  logic        cts_n;
  logic        txd, rts_n, tx_busy, tx_full, tx_empty, tx_overflow, rx_full;

  int n_tests;
  int n_fail;
  int frames;
  logic [7:0] exp_q[$];

  uart_flow_tx u_uart_flow_tx (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .baud_tick(baud_tick), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_level(rx_level), .cts_n(cts_n), .txd(txd), .rts_n(rts_n),
    .tx_busy(tx_busy), .tx_full(tx_full), .tx_empty(tx_empty),
    .tx_overflow(tx_overflow), .rx_full(rx_full)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) baud_tick <= 1'b0;
    else        baud_tick <= ~baud_tick;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_ctrl(input bit en, input bit rts, input bit cts, input int wm);
    @(negedge clk);
    ctrl_we    = 1'b1;
    ctrl_wdata = '0;
    ctrl_wdata[0]    = en;
    ctrl_wdata[12:8] = 5'(wm);
    ctrl_wdata[14]   = rts;
    ctrl_wdata[15]   = cts;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d, input bit accepted);
    @(negedge clk);
    tx_wr   = 1'b1;
    tx_data = d;
    if (accepted) exp_q.push_back(d);
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_frames(input int target, input string req);
    for (int i = 0; i < 20000 && frames < target; i++) @(negedge clk);
    check(req, "frame count", frames, target);
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 2000 && !tx_busy; i++) @(negedge clk);
  endtask

  // Monitor: decodes frames on txd and compares against the scoreboard queue
  initial begin
    logic [7:0] got;
    frames = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd == 1'b0) begin
        repeat (BIT_CYC/2 - 1) @(negedge clk);
        check("R2", "start bit", int'(txd), 0);
        for (int b = 0; b < 8; b++) begin
          repeat (BIT_CYC) @(negedge clk);
          got[b] = txd;
        end
        repeat (BIT_CYC) @(negedge clk);
        check("R2", "stop bit", int'(txd), 1);
        if (exp_q.size() == 0) begin
          n_tests++;
          n_fail++;
          $display("FAIL R2: unexpected frame actual %0h expected none", got);
        end else begin
          check("R2", "frame data", int'(got), int'(exp_q.pop_front()));
        end
        frames++;
        repeat (BIT_CYC/2 - 2) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; tx_wr = 1'b0;
    tx_data = '0; rx_level = '0; cts_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "txd", int'(txd), 1);
    check("R1", "rts_n", int'(rts_n), 0);
    check("R1", "tx_busy", int'(tx_busy), 0);
    check("R1", "tx_empty", int'(tx_empty), 1);
    check("R1", "tx_full", int'(tx_full), 0);
    check("R1", "tx_overflow", int'(tx_overflow), 0);

    // R10 receive full flag
    rx_level = 5'd16; #1;
    check("R10", "rx_full at 16", int'(rx_full), 1);
    rx_level = 5'd15; #1;
    check("R10", "rx_full at 15", int'(rx_full), 0);

    // R9 request-to-send off keeps rts_n low
    rx_level = 5'd16;
    repeat (2) @(negedge clk);
    check("R9", "rts_n with rts disabled", int'(rts_n), 0);

    // R8 watermark 8, one-cycle latency
    write_ctrl(0, 1, 0, 8);
    rx_level = 5'd7; @(negedge clk);
    check("R8", "rts_n level 7", int'(rts_n), 0);
    rx_level = 5'd8; @(negedge clk);
    check("R8", "rts_n level 8", int'(rts_n), 1);
    rx_level = 5'd12; @(negedge clk);
    check("R8", "rts_n level 12", int'(rts_n), 1);
    rx_level = 5'd7; @(negedge clk);
    check("R8", "rts_n back to 7", int'(rts_n), 0);
    write_ctrl(0, 0, 0, 8);
    rx_level = 5'd12; repeat (2) @(negedge clk);
    check("R9", "rts_n after disabling rts", int'(rts_n), 0);

    // R2 back-to-back frames, CTS gating off, cts_n high ignored
    write_ctrl(1, 0, 0, 0);
    cts_n = 1'b1;
    write_byte(8'hA5, 1);
    write_byte(8'h3C, 1);
    write_byte(8'hFF, 1);
    wait_frames(3, "R2");

    // R7 enabled write changes only enable: cts gating stays off
    write_ctrl(1, 0, 1, 0);
    write_byte(8'h81, 1);
    wait_frames(4, "R7");

    // R4 cts gating on, cts_n high holds the character
    write_ctrl(0, 0, 0, 0);
    write_ctrl(1, 0, 1, 0);
    write_byte(8'h5A, 1);
    repeat (1000) @(negedge clk);
    check("R4", "frames while cts_n high", frames, 4);
    check("R4", "tx_busy while cts_n high", int'(tx_busy), 0);
    check("R4", "tx_empty while held", int'(tx_empty), 0);
    cts_n = 1'b0;
    wait_frames(5, "R4");

    // R5 cts_n rises mid-character
    write_byte(8'h11, 1);
    write_byte(8'h22, 1);
    wait_busy();
    repeat (50) @(negedge clk);
    cts_n = 1'b1;
    wait_frames(6, "R5");
    repeat (800) @(negedge clk);
    check("R5", "frames after cts_n rise", frames, 6);
    check("R5", "tx_empty holds next", int'(tx_empty), 0);
    cts_n = 1'b0;
    wait_frames(7, "R5");

    // R6 disable mid-character
    write_ctrl(0, 0, 0, 0);
    write_ctrl(1, 0, 0, 0);
    write_byte(8'h33, 1);
    write_byte(8'h44, 1);
    wait_busy();
    repeat (50) @(negedge clk);
    write_ctrl(0, 0, 0, 0);
    wait_frames(8, "R6");
    repeat (800) @(negedge clk);
    check("R6", "frames while disabled", frames, 8);
    check("R6", "tx_busy while disabled", int'(tx_busy), 0);
    check("R6", "tx_empty while disabled", int'(tx_empty), 0);
    write_ctrl(1, 0, 0, 0);
    wait_frames(9, "R6");

    // R3 queue depth and overflow
    write_ctrl(0, 0, 0, 0);
    for (int k = 0; k < 16; k++) write_byte(8'(8'h60 + k), 1);
    check("R3", "tx_full at 16", int'(tx_full), 1);
    check("R3", "tx_overflow before drop", int'(tx_overflow), 0);
    write_byte(8'hEE, 0);
    check("R3", "tx_overflow after drop", int'(tx_overflow), 1);
    base = frames;
    write_ctrl(1, 0, 0, 0);
    wait_frames(base + 16, "R3");
    check("R3", "tx_overflow sticky", int'(tx_overflow), 1);
    check("R3", "tx_empty after drain", int'(tx_empty), 1);
    check("R3", "scoreboard left", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule